// File: doc/BRIEF.md
# Reset Configuration Word Fetcher

After reset is released this block plays the configuration master on a boot memory device. It walks a fixed set of byte-wide reads through the boot device and collects 32-bit configuration words from them. The first word is for the block's own core. Each of the next seven is for one configuration slave. Every read lands on a 64-bit boundary and only one byte lane of the 64-bit data bus is used, so the boot device's port width makes no difference.

Once the master word is complete, its core-initial-prefix bit picks the exception base: either the bottom of the address space or the 0xFFF00000 region. The block outputs the system reset vector address, which is that base plus 0x100. When the last read completes, the block raises a done flag and holds every output until the next reset.

The sequencer has four states:

| State | Meaning | Leaves to |
|---|---|---|
| S_IDLE | Reset state. | Always moves to S_ISSUE on the next clock. |
| S_ISSUE | Drives the read strobe for one cycle. | S_WAIT. |
| S_WAIT | Holds the address and waits for data-valid. | S_ISSUE on a valid byte that is not the last one; S_DONE on the last valid byte; otherwise stays in S_WAIT. |
| S_DONE | Terminal until reset. | Nowhere. |

Top module: `rcw_fetch`

## Requirements
- R1: After reset the block issues exactly 32 read strobes, each one cycle long, the first at address 0. No strobe is issued during reset or after done.
- R2: Read number n (counting from 0) is issued at address 8*n, so the low three address bits are always zero.
- R3: Each read captures only rd_data[63:56]. Bits 55:0 have no effect on any output.
- R4: Reads 4k to 4k+3 build word k. Word 0 appears on master_word. Word k (k = 1..7) appears on slave_words[32*k-1 -: 32], so slave 1 sits in bits 31:0.
- R5: Within a word, the first read of the group fills bits 31:24, the second fills 23:16, the third fills 15:8 and the fourth fills 7:0.
- R6: slave_valid[k-1] rises in the cycle after the fourth byte of word k is captured and stays set until reset. All seven bits are set when done is set.
- R7: The sequencer does not advance until rd_valid is seen while a read is outstanding, whatever the latency. An rd_valid pulse with no outstanding read (for example after done) is ignored.
- R8: done rises in the cycle after the 32nd byte is captured and stays high. While done is high, master_word, slave_words, slave_valid and vec_addr do not change.
- R9: vec_addr is 32'h0000_0100 when bit 22 of master_word is 0 and 32'h FFF0_0100 when that bit is 1.
- R10: While reset is asserted, master_word, slave_words and slave_valid are zero, done and rd_req are 0, and vec_addr is 32'h0000_0100. A reset in the middle of a fetch restarts the sequence at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | output | 1 | One-cycle read strobe |
| rd_addr | output | 32 | Byte address of the current read |
| rd_valid | input | 1 | Read data is valid this cycle |
| rd_data | input | 64 | Boot device data bus; only bits 63:56 are used |
| master_word | output | 32 | Assembled configuration word for this core |
| slave_words | output | 224 | Seven slave words, slave 1 in bits 31:0 |
| slave_valid | output | 7 | Per-slave word complete flags |
| vec_addr | output | 32 | System reset vector address |
| done | output | 1 | All 32 reads complete |

## Verification
The hardest case to reach from the ports is a fetch stopped partway through: some slave words are complete and others are not. The bench counts the data-valid pulses its boot-device model returns. It stops after the twelfth to check that exactly two slave flags are set. In another run it asserts reset after twenty bytes and checks that the next sequence starts again at address 0. The device model fills the unused byte lanes with a pattern that changes with the address, so a wrong lane shows up in the assembled words. After done, the bench drives stray valid pulses carrying different data and checks that nothing moves.

// File: rtl/rcwf_pkg.sv
package rcwf_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2,
        S_DONE  = 2'd3
    } fetch_state_t;

endpackage

// File: rtl/rcwf_seq.sv
module rcwf_seq
    import rcwf_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int N_READS = 32,
    parameter int STRIDE  = 8,
    parameter int IDX_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              cap_en,
    output logic [IDX_W-1:0]  cap_idx,
    output logic              done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_READS - 1);

    fetch_state_t state_q;
    fetch_state_t state_d;
    logic [IDX_W-1:0] idx_q;
    logic             last_byte;

    assign last_byte = (idx_q == LAST_IDX);
    assign cap_en    = (state_q == S_WAIT) && rd_valid;
    assign cap_idx   = idx_q;
    assign rd_addr   = ADDR_W'(idx_q) * ADDR_W'(STRIDE);

    // state register and read counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (cap_en && !last_byte) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  state_d = S_ISSUE;
            S_ISSUE: state_d = S_WAIT;
            S_WAIT: begin
                if (rd_valid) begin
                    state_d = last_byte ? S_DONE : S_ISSUE;
                end
            end
            S_DONE:  state_d = S_DONE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        rd_req = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            S_IDLE:  ;
            S_ISSUE: rd_req = 1'b1;
            S_WAIT:  ;
            S_DONE:  done = 1'b1;
        endcase
    end

endmodule

// File: rtl/rcwf_asm.sv
module rcwf_asm
    import rcwf_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int N_WORDS = 8,
    parameter int IDX_W   = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cap_en,
    input  logic [IDX_W-1:0]            cap_idx,
    input  logic [BYTE_W-1:0]           cap_byte,
    output logic [WORD_W-1:0]           word0,
    output logic [(N_WORDS-1)*WORD_W-1:0] others,
    output logic [N_WORDS-2:0]          others_vld
);

    localparam int BPW = WORD_W / BYTE_W;

    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        logic [WORD_W-1:0] wq;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wq <= '0;
            end else if (cap_en) begin
                for (int b = 0; b < BPW; b++) begin
                    if (cap_idx == IDX_W'(w * BPW + b)) begin
                        wq[WORD_W-1-BYTE_W*b -: BYTE_W] <= cap_byte;
                    end
                end
            end
        end

        if (w == 0) begin : g_master
            assign word0 = wq;
        end else begin : g_slave
            logic vq;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vq <= 1'b0;
                end else if (cap_en && cap_idx == IDX_W'(w * BPW + BPW - 1)) begin
                    vq <= 1'b1;
                end
            end
            assign others[(w-1)*WORD_W +: WORD_W] = wq;
            assign others_vld[w-1]                = vq;
        end
    end

endmodule

// File: rtl/rcwf_vec.sv
module rcwf_vec #(
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] LO_BASE    = 32'h0000_0000,
    parameter logic [31:0] HI_BASE    = 32'hFFF0_0000,
    parameter logic [31:0] VEC_OFFSET = 32'h0000_0100
) (
    input  logic              prefix,
    output logic [ADDR_W-1:0] vec_addr
);

    localparam logic [ADDR_W-1:0] VEC_LO = ADDR_W'(LO_BASE + VEC_OFFSET);
    localparam logic [ADDR_W-1:0] VEC_HI = ADDR_W'(HI_BASE + VEC_OFFSET);

    assign vec_addr = prefix ? VEC_HI : VEC_LO;

endmodule

// File: rtl/rcw_fetch.sv
module rcw_fetch
    import rcwf_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          BUS_W      = 64,
    parameter int          WORD_W     = 32,
    parameter int          N_WORDS    = 8,
    parameter int          STRIDE     = 8,
    parameter int          PREFIX_BIT = 22,
    parameter logic [31:0] LO_BASE    = 32'h0000_0000,
    parameter logic [31:0] HI_BASE    = 32'hFFF0_0000,
    parameter logic [31:0] VEC_OFFSET = 32'h0000_0100
) (
    input  logic                          clk,
    input  logic                          rst_n,
    output logic                          rd_req,
    output logic [ADDR_W-1:0]             rd_addr,
    input  logic                          rd_valid,
    input  logic [BUS_W-1:0]              rd_data,
    output logic [WORD_W-1:0]             master_word,
    output logic [(N_WORDS-1)*WORD_W-1:0] slave_words,
    output logic [N_WORDS-2:0]            slave_valid,
    output logic [ADDR_W-1:0]             vec_addr,
    output logic                          done
);

    localparam int BPW     = WORD_W / BYTE_W;
    localparam int N_READS = N_WORDS * BPW;
    localparam int IDX_W   = $clog2(N_READS);

    logic              cap_en;
    logic [IDX_W-1:0]  cap_idx;
    logic [BYTE_W-1:0] cap_byte;
    logic              unused_lanes;

    // only the top byte lane carries configuration data
    assign cap_byte     = rd_data[BUS_W-1 -: BYTE_W];
    assign unused_lanes = ^rd_data[BUS_W-BYTE_W-1:0];

    rcwf_seq #(
        .ADDR_W  (ADDR_W),
        .N_READS (N_READS),
        .STRIDE  (STRIDE),
        .IDX_W   (IDX_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_valid (rd_valid),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .cap_en   (cap_en),
        .cap_idx  (cap_idx),
        .done     (done)
    );

    rcwf_asm #(
        .WORD_W  (WORD_W),
        .N_WORDS (N_WORDS),
        .IDX_W   (IDX_W)
    ) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en     (cap_en),
        .cap_idx    (cap_idx),
        .cap_byte   (cap_byte),
        .word0      (master_word),
        .others     (slave_words),
        .others_vld (slave_valid)
    );

    rcwf_vec #(
        .ADDR_W     (ADDR_W),
        .LO_BASE    (LO_BASE),
        .HI_BASE    (HI_BASE),
        .VEC_OFFSET (VEC_OFFSET)
    ) u_vec (
        .prefix   (master_word[PREFIX_BIT]),
        .vec_addr (vec_addr)
    );

endmodule

// File: rtl/rcw_fetch_chk.sv
module rcw_fetch_chk #(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int N_WORDS    = 8,
    parameter int STRIDE     = 8,
    parameter int PREFIX_BIT = 22
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          rd_req,
    input logic [ADDR_W-1:0]             rd_addr,
    input logic [WORD_W-1:0]             master_word,
    input logic [(N_WORDS-1)*WORD_W-1:0] slave_words,
    input logic [N_WORDS-2:0]            slave_valid,
    input logic [ADDR_W-1:0]             vec_addr,
    input logic                          done
);

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr % ADDR_W'(STRIDE)) == '0); // R2

    AST_NO_REQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_req); // R1

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done); // R8

    AST_HOLD_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(master_word) && $stable(slave_words) && $stable(vec_addr))); // R8

    AST_VALID_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((slave_valid & $past(slave_valid)) == $past(slave_valid))); // R6

    AST_ALL_VALID_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (&slave_valid)); // R6

    AST_VEC_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (vec_addr == (master_word[PREFIX_BIT] ? 32'hFFF0_0100 : 32'h0000_0100))); // R9

endmodule

bind rcw_fetch rcw_fetch_chk #(
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W),
    .N_WORDS    (N_WORDS),
    .STRIDE     (STRIDE),
    .PREFIX_BIT (PREFIX_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_req      (rd_req),
    .rd_addr     (rd_addr),
    .master_word (master_word),
    .slave_words (slave_words),
    .slave_valid (slave_valid),
    .vec_addr    (vec_addr),
    .done        (done)
);

// File: tb/rcw_fetch_test.sv
`timescale 1ns/1ps
module rcw_fetch_test;

    typedef struct packed {
        logic [3:0]  lat;
        logic [31:0] master;
        logic [31:0] seed;
    } row_t;

    localparam int NROWS = 4;
    localparam row_t TBL [NROWS] = '{
        '{4'd1, 32'h0040_1234, 32'h1000_0001},
        '{4'd3, 32'h12B3_C4D5, 32'hCAFE_0F0F},
        '{4'd7, 32'hFFBF_FFFF, 32'h0000_0000},
        '{4'd2, 32'h0040_0000, 32'h89AB_CDEF}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rd_req;
    logic [31:0]  rd_addr;
    logic         rd_valid;
    logic [63:0]  rd_data;
    logic [31:0]  master_word;
    logic [223:0] slave_words;
    logic [6:0]   slave_valid;
    logic [31:0]  vec_addr;
    logic         done;

    int errors = 0;
    int checks = 0;

    logic [3:0]  cur_lat = 4'd1;
    logic [31:0] cur_master = '0;
    logic [31:0] cur_seed = '0;

    logic        dev_valid;
    logic [63:0] dev_data;
    logic        inj_valid = 1'b0;
    logic [63:0] inj_data = '0;
    logic        pend;
    logic [3:0]  cnt;
    logic [31:0] paddr;
    int          exp_n, nreads, vcount, addr_err;

    always #10 clk = ~clk;

    assign rd_valid = dev_valid | inj_valid;
    assign rd_data  = inj_valid ? inj_data : dev_data;

    rcw_fetch uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_req      (rd_req),
        .rd_addr     (rd_addr),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .master_word (master_word),
        .slave_words (slave_words),
        .slave_valid (slave_valid),
        .vec_addr    (vec_addr),
        .done        (done)
    );

    function automatic logic [31:0] exp_word(int k);
        if (k == 0) return cur_master;
        return (cur_seed ^ (32'(k) * 32'h0F1E_2D3C)) + 32'(k);
    endfunction

    function automatic logic [63:0] mk_data(logic [31:0] a);
        int n = int'(a) / 8;
        logic [31:0] w = exp_word(n / 4);
        logic [7:0]  b = w[31 - 8*(n % 4) -: 8];
        return {b, 56'hA5_5A3C_C396_69F0 ^ {24'h0, a}};
    endfunction

    // boot device model
    always @(posedge clk) begin
        dev_valid <= 1'b0;
        if (!rst_n) begin
            pend <= 1'b0; cnt <= '0; paddr <= '0;
            exp_n <= 0; nreads <= 0; vcount <= 0; addr_err <= 0;
            dev_data <= '0;
        end else begin
            if (dev_valid) vcount <= vcount + 1;
            if (pend) begin
                if (cnt == 0) begin
                    dev_valid <= 1'b1;
                    dev_data  <= mk_data(paddr);
                    pend      <= 1'b0;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end else if (rd_req) begin
                pend  <= 1'b1;
                cnt   <= cur_lat - 1'b1;
                paddr <= rd_addr;
                if (rd_addr != 32'(exp_n * 8)) addr_err <= addr_err + 1;
                exp_n  <= exp_n + 1;
                nreads <= nreads + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (done) break;
        end
    endtask

    task automatic check_all(input string name);
        logic [223:0] exp_sl;
        logic [31:0]  exp_vec;
        for (int k = 1; k < 8; k++) exp_sl[32*k-1 -: 32] = exp_word(k);
        exp_vec = cur_master[22] ? 32'hFFF0_0100 : 32'h0000_0100;
        chk(done == 1'b1, {name, " R8 done"}, 256'(done), 256'(1));
        chk(master_word == cur_master, {name, " R4 R5 R3 master"}, 256'(master_word), 256'(cur_master));
        chk(slave_words == exp_sl, {name, " R4 R5 R3 slaves"}, 256'(slave_words), 256'(exp_sl));
        chk(slave_valid == 7'h7F, {name, " R6 all valid"}, 256'(slave_valid), 256'(7'h7F));
        chk(vec_addr == exp_vec, {name, " R9 vector"}, 256'(vec_addr), 256'(exp_vec));
        chk(nreads == 32, {name, " R1 read count"}, 256'(nreads), 256'(32));
        chk(addr_err == 0, {name, " R2 address steps"}, 256'(addr_err), 256'(0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R10 reset state
        repeat (2) @(negedge clk);
        chk(master_word == 0 && slave_words == 0 && slave_valid == 0, "R10 reset words",
            256'(master_word), 256'(0));
        chk(!done && !rd_req, "R10 reset done/req", 256'({done, rd_req}), 256'(0));
        chk(vec_addr == 32'h0000_0100, "R10 reset vector", 256'(vec_addr), 256'(32'h100));

        // table walk: latency and contents vary per row (R7 tolerates latency)
        for (int r = 0; r < NROWS; r++) begin
            cur_lat    = TBL[r].lat;
            cur_master = TBL[r].master;
            cur_seed   = TBL[r].seed;
            do_reset();
            wait_done();
            check_all($sformatf("row%0d", r));
            repeat (10) @(negedge clk);
            chk(nreads == 32, "R1 no reads after done", 256'(nreads), 256'(32));
        end

        // partial fetch: two slave words complete after 12 bytes (R6)
        cur_lat = 4'd5; cur_master = 32'h0040_7777; cur_seed = 32'h5555_AAAA;
        do_reset();
        wait (vcount == 12);
        @(negedge clk);
        chk(slave_valid == 7'b0000011, "R6 partial valid", 256'(slave_valid), 256'(7'b0000011));
        chk(slave_words[63:0] == {exp_word(2), exp_word(1)}, "R4 partial slave words",
            256'(slave_words[63:0]), 256'({exp_word(2), exp_word(1)}));
        chk(done == 1'b0, "R8 not done mid fetch", 256'(done), 256'(0));

        // stray valid pulses after done must change nothing (R7, R8)
        wait_done();
        inj_data  = 64'hFFFF_FFFF_FFFF_FFFF;
        inj_valid = 1'b1;
        repeat (3) @(negedge clk);
        inj_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(master_word == cur_master, "R7 stray valid ignored", 256'(master_word), 256'(cur_master));
        chk(done && nreads == 32, "R8 done held", 256'({done, 8'(nreads)}), 256'({1'b1, 8'd32}));

        // reset in the middle of a fetch restarts at address 0 (R10)
        cur_lat = 4'd2; cur_master = 32'h0000_0042; cur_seed = 32'h0BAD_F00D;
        do_reset();
        wait (vcount == 20);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(master_word == 0 && slave_valid == 0 && !done && !rd_req, "R10 mid-run reset",
            256'({master_word, slave_valid, done}), 256'(0));
        rst_n = 1'b1;
        wait_done();
        check_all("restart R10");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule